// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks through the elements of one vector instruction and hands a scalar execution unit one element operation at a time. Each operation names two source registers and one destination register. The block keeps two separate step counters, one on the source side and one on the destination side. Each counter passes over the elements that its own mask disables.

Because the two sides skip on their own, one block covers four cases:
- packing enabled source elements into consecutive destinations (compress);
- spreading consecutive sources into enabled destinations (expand);
- doing both at once;
- skipping elements in place, when one mask drives both sides.

A scalar destination ends the instruction after its first operation. A scalar source supplies the same register for every element. A vector length of zero issues nothing.

The issue side uses a valid/ready handshake. A done pulse marks the end of each instruction so the next one can start.

Top module: `elem_seq`

## Requirements
- R1: When the clamped vector length is 0, no request is issued, and `done` is high for one cycle in the cycle after `start` is taken.
- R2: The source step passes over every element whose source-mask bit is 0. Bit i of a mask enables element i. The n-th request pairs the n-th enabled source element with the n-th enabled destination element.
- R3: The destination step passes over every element whose destination-mask bit is 0. Skipped destination indices never appear on `req_didx`.
- R4: When an invert flag is 1, the bitwise complement of that mask is used in place of the mask.
- R5: When `single_pred` is 1, the source mask (after its invert flag) governs both sides, and `dst_mask` and `dst_mask_inv` have no effect. Elements are then skipped in place (`req_sidx` equals `req_didx`), and an all-zero mask issues nothing.
- R6: When `dst_vec` is 0, the instruction ends after its first accepted request.
- R7: A vector operand's register number is its base plus its step index, modulo 128. A scalar operand's register number is its base for every element.
- R8: At most one request is accepted per clock, on a cycle where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the request and all of its fields stay unchanged.
- R9: `done` is a one-cycle pulse. It comes in the cycle after the last accepted request, and after reset `done` and `req_valid` are low.
- R10: A `start` received while an instruction is running is ignored, and so are input changes made at that time.
- R11: A vector length above 64 is treated as 64.
- R12: Both steps return to 0 at the end of every instruction, so the next instruction's first request has the lowest enabled indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction; taken only when idle |
| vl | input | 7 | Vector length |
| dst_base | input | 7 | Destination base register |
| dst_vec | input | 1 | 1 = destination is a vector |
| srca_base | input | 7 | First source base register |
| srca_vec | input | 1 | 1 = first source is a vector |
| srcb_base | input | 7 | Second source base register |
| srcb_vec | input | 1 | 1 = second source is a vector |
| src_mask | input | 64 | Source predicate value |
| src_mask_inv | input | 1 | Use the complement of `src_mask` |
| dst_mask | input | 64 | Destination predicate value |
| dst_mask_inv | input | 1 | Use the complement of `dst_mask` |
| single_pred | input | 1 | One mask governs both sides |
| req_valid | output | 1 | Element request present |
| req_ready | input | 1 | Execution unit accepts the request |
| req_srca | output | 7 | First source register of the request |
| req_srcb | output | 7 | Second source register of the request |
| req_dst | output | 7 | Destination register of the request |
| req_sidx | output | 6 | Source element index |
| req_didx | output | 6 | Destination element index |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The assertions assume two things about the environment. First, `req_ready` is a plain level sampled at the clock edge. Second, `start` may arrive at any time, busy or not, so they do not depend on any start discipline.

The bench drives all inputs on the falling edge, so at each rising edge every input is already stable. It mixes directed mask and length patterns with random masks and lengths up to 70, and it varies `req_ready` at random to exercise stalls. A start with altered inputs is injected only when at least one request is still to come, so the busy flag is certainly set at that edge.

// File: rtl/elem_seq.sv
module elem_seq #(
  parameter int REGW  = 7,
  parameter int VLW   = 7,
  parameter int MAXVL = 64,
  parameter int IDXW  = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic [REGW-1:0]  dst_base,
  input  logic             dst_vec,
  input  logic [REGW-1:0]  srca_base,
  input  logic             srca_vec,
  input  logic [REGW-1:0]  srcb_base,
  input  logic             srcb_vec,
  input  logic [MAXVL-1:0] src_mask,
  input  logic             src_mask_inv,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             dst_mask_inv,
  input  logic             single_pred,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [REGW-1:0]  req_srca,
  output logic [REGW-1:0]  req_srcb,
  output logic [REGW-1:0]  req_dst,
  output logic [IDXW-1:0]  req_sidx,
  output logic [IDXW-1:0]  req_didx,
  output logic             done
);
  localparam int STW = IDXW + 1;

  logic             busy;
  logic [STW-1:0]   sstep, dstep;
  logic [MAXVL-1:0] smq, dmq;
  logic [REGW-1:0]  dbase_q, abase_q, bbase_q;
  logic             dvec_q, avec_q, bvec_q;

  logic [STW-1:0]   evl_in;
  logic [MAXVL-1:0] lenmask, sm_in, dm_in;

  assign evl_in = (int'(vl) > MAXVL) ? STW'(MAXVL) : STW'(vl);

  always_comb begin
    for (int i = 0; i < MAXVL; i++) lenmask[i] = (i < int'(evl_in));
  end

  assign sm_in = (src_mask_inv ? ~src_mask : src_mask) & lenmask;
  assign dm_in = single_pred ? sm_in
               : ((dst_mask_inv ? ~dst_mask : dst_mask) & lenmask);

  logic           s_ok, d_ok, fire, s_more, d_more, last;
  logic [STW-1:0] snext, dnext;

  assign s_ok   = smq[sstep[IDXW-1:0]];
  assign d_ok   = dmq[dstep[IDXW-1:0]];
  assign snext  = sstep + 1'b1;
  assign dnext  = dstep + 1'b1;
  assign s_more = |(smq >> snext);
  assign d_more = |(dmq >> dnext);
  assign last   = !dvec_q || !s_more || !d_more;

  assign req_valid = busy && s_ok && d_ok;
  assign fire      = req_valid && req_ready;

  assign req_sidx = sstep[IDXW-1:0];
  assign req_didx = dstep[IDXW-1:0];
  assign req_srca = avec_q ? abase_q + REGW'(sstep) : abase_q;
  assign req_srcb = bvec_q ? bbase_q + REGW'(sstep) : bbase_q;
  assign req_dst  = dvec_q ? dbase_q + REGW'(dstep) : dbase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sstep   <= '0;
      dstep   <= '0;
      smq     <= '0;
      dmq     <= '0;
      dbase_q <= '0;
      abase_q <= '0;
      bbase_q <= '0;
      dvec_q  <= 1'b0;
      avec_q  <= 1'b0;
      bvec_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          smq     <= sm_in;
          dmq     <= dm_in;
          dbase_q <= dst_base;
          abase_q <= srca_base;
          bbase_q <= srcb_base;
          dvec_q  <= dst_vec;
          avec_q  <= srca_vec;
          bvec_q  <= srcb_vec;
          if (!(|sm_in) || !(|dm_in)) done <= 1'b1;
          else                        busy <= 1'b1;
        end
      end else if (fire) begin
        if (last) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          sstep <= '0;
          dstep <= '0;
        end else begin
          sstep <= snext;
          dstep <= dnext;
        end
      end else begin
        if (!s_ok) sstep <= snext;
        if (!d_ok) dstep <= dnext;
      end
    end
  end

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_dst)
      && $stable(req_srca) && $stable(req_srcb) && $stable(req_sidx) && $stable(req_didx));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  a_r1_vl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && vl == '0 |=> done && !req_valid);

  a_r6_scalar_dst: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !dvec_q |=> done && !req_valid);

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sstep == '0 && dstep == '0);

  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(dbase_q) && $stable(smq) && $stable(dmq));

  a_r5_in_place: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && smq == dmq |-> req_sidx == req_didx);
endmodule

// File: tb/test_elem_seq.sv
module test_elem_seq;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [6:0]  vl = 0, dst_base = 0, srca_base = 0, srcb_base = 0;
  logic        dst_vec = 0, srca_vec = 0, srcb_vec = 0;
  logic [63:0] src_mask = 0, dst_mask = 0;
  logic        src_mask_inv = 0, dst_mask_inv = 0, single_pred = 0;
  logic        req_valid, req_ready = 0, done;
  logic [6:0]  req_srca, req_srcb, req_dst;
  logic [5:0]  req_sidx, req_didx;

  int checks = 0, errors = 0, cyc = 0;

  elem_seq i_elem_seq (.*);

  always #10 clk = ~clk;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL R9 watchdog: actual %0d expected <150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  int exp_s[$], exp_d[$];

  task automatic model(int vlen, logic [63:0] sm, logic [63:0] dm, bit dvec);
    int s = 0, d = 0;
    exp_s.delete(); exp_d.delete();
    if (vlen > 64) vlen = 64;
    forever begin
      while (s < vlen && !sm[s]) s++;
      while (d < vlen && !dm[d]) d++;
      if (s >= vlen || d >= vlen) break;
      exp_s.push_back(s); exp_d.push_back(d);
      s++; d++;
      if (!dvec) break;
    end
  endtask

  task automatic run_op(string tag, int vlen, int ab, bit av, int bb, bit bv, int db, bit dv,
                        logic [63:0] sm, bit si, logic [63:0] dm, bit di, bit sp,
                        bit rnd_ready, bit poke);
    logic [63:0] esm, edm;
    int c = 0, k = 0, done_cyc = -1, last_fire = -1;
    bit stall = 0;
    logic [6:0] pa = 0, pb = 0, pd = 0;
    esm = si ? ~sm : sm;
    edm = sp ? esm : (di ? ~dm : dm);
    model(vlen, esm, edm, dv);
    @(negedge clk);
    vl = 7'(vlen); srca_base = 7'(ab); srca_vec = av; srcb_base = 7'(bb); srcb_vec = bv;
    dst_base = 7'(db); dst_vec = dv; src_mask = sm; src_mask_inv = si;
    dst_mask = dm; dst_mask_inv = di; single_pred = sp; start = 1;
    @(negedge clk);
    start = 0;
    while (c < 400) begin
      if (poke && c == 0 && exp_s.size() > 0) begin
        start = 1; vl = 0; src_mask = 0; dst_mask = 0; dst_base = 7'(db + 5); dst_vec = ~dv;
      end else start = 0;
      req_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (stall) begin
        chk(req_valid && req_srca == pa && req_srcb == pb && req_dst == pd, "R8",
            "request held under stall", {req_valid, req_srca, req_dst}, {1'b1, pa, pd});
      end
      if (done) begin
        if (done_cyc >= 0) chk(0, "R9", "second done pulse", c, done_cyc);
        else done_cyc = c;
      end
      if (done_cyc >= 0 && c == done_cyc + 1) begin
        chk(!done, "R9", "done is one cycle", done, 0);
        break;
      end
      if (req_valid && req_ready) begin
        if (k < exp_s.size()) begin
          chk(req_sidx == exp_s[k], tag, "source index", req_sidx, exp_s[k]);
          chk(req_didx == exp_d[k], tag, "destination index", req_didx, exp_d[k]);
          chk(req_srca == 7'(av ? ab + exp_s[k] : ab), "R7", "srca register", req_srca,
              7'(av ? ab + exp_s[k] : ab));
          chk(req_srcb == 7'(bv ? bb + exp_s[k] : bb), "R7", "srcb register", req_srcb,
              7'(bv ? bb + exp_s[k] : bb));
          chk(req_dst == 7'(dv ? db + exp_d[k] : db), "R7", "dst register", req_dst,
              7'(dv ? db + exp_d[k] : db));
        end else chk(0, tag, "extra request", k, exp_s.size());
        k++;
        last_fire = c;
      end
      stall = req_valid && !req_ready;
      pa = req_srca; pb = req_srcb; pd = req_dst;
      @(negedge clk);
      c++;
    end
    start = 0;
    chk(k == exp_s.size(), tag, "request count", k, exp_s.size());
    if (exp_s.size() == 0) chk(done_cyc == 0, "R1", "done right after start", done_cyc, 0);
    else chk(done_cyc == last_fire + 1, "R9", "done after last handshake", done_cyc, last_fire + 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!done && !req_valid, "R9", "reset outputs quiet", {done, req_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    run_op("R1", 0, 7, 1, 9, 1, 13, 1, '1, 0, '1, 0, 0, 0, 0);
    run_op("R2", 3, 9, 1, 9, 1, 5, 1, 64'b101, 0, '1, 0, 0, 0, 0);
    run_op("R3", 3, 9, 1, 9, 1, 5, 1, '1, 0, 64'b101, 0, 0, 1, 0);
    run_op("R4", 3, 9, 1, 9, 1, 5, 1, 64'b101, 0, 64'b101, 1, 0, 0, 0);
    run_op("R4", 2, 9, 1, 9, 1, 5, 1, 64'b10, 1, 64'b10, 0, 0, 0, 0);
    run_op("R5", 3, 5, 1, 9, 1, 1, 1, 64'b101, 0, 64'b010, 0, 1, 0, 0);
    run_op("R5", 3, 5, 1, 9, 1, 1, 1, 64'b0, 0, '1, 0, 1, 0, 0);
    run_op("R6", 2, 5, 1, 9, 1, 1, 0, '1, 0, '1, 0, 0, 0, 0);
    run_op("R7", 8, 126, 0, 125, 1, 122, 1, '1, 0, '1, 0, 0, 1, 0);
    run_op("R11", 100, 0, 1, 64, 1, 100, 1, '1, 0, '1, 0, 0, 0, 0);
    run_op("R10", 6, 3, 1, 40, 1, 20, 1, 64'h2d, 0, '1, 0, 0, 1, 1);
    run_op("R12", 3, 1, 1, 5, 1, 9, 1, '1, 0, '1, 0, 0, 0, 0);
    run_op("R12", 3, 1, 1, 5, 1, 9, 1, '1, 0, '1, 0, 0, 0, 0);
    for (int n = 0; n < 60; n++) begin
      run_op("R2", $urandom % 71, $urandom % 128, 1'($urandom), $urandom % 128, 1'($urandom),
             $urandom % 128, ($urandom % 5 != 0), {$urandom, $urandom}, 1'($urandom),
             {$urandom, $urandom}, 1'($urandom), ($urandom % 4 == 0), 1'($urandom),
             ($urandom % 3 == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule